// File: doc/BRIEF.md
# Passive Color LCD Frame and Line Timing Generator

This block derives the raster timing for a passive color LCD panel from four programmable fields. It counts pixel clocks along a line and lines down a frame, marks which positions fall inside the visible area, and issues a line strobe on every line and a frame strobe once per frame. Downstream logic uses the display-enable flag together with the two counters to fetch and format pixels.

Horizontal lengths are programmed in groups of eight pixel clocks, written as the group count minus one. Vertical lengths are programmed in lines. The visible height is the vertical display field plus one, and the blank height is the vertical total field minus the vertical display field. All four fields are copied into shadow registers only at the start of a frame, so software may rewrite them at any time without tearing the frame in progress.

Top module: `lcd_panel_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, disp_en, line_pulse, frame_pulse, pix_cnt and line_cnt are all 0. The first frame starts at the first clock edge after release, where all four fields are captured.
- R2: pix_cnt steps by one each pixel clock from 0 to (cfg_htotal+1)*8-1 and then returns to 0.
- R3: line_cnt steps by one when pix_cnt wraps, runs from 0 to cfg_vtotal and then returns to 0, giving cfg_vtotal+1 lines per frame.
- R4: disp_en is 1 exactly when pix_cnt < (cfg_hdisp+1)*8 and line_cnt <= cfg_vdisp.
- R5: line_pulse is 1 for the 8 pixel clocks with pix_cnt/8 == cfg_hdisp+1 when cfg_hdisp < cfg_htotal, on every line including blank lines.
- R6: frame_pulse is 1 for the whole line where line_cnt == cfg_vdisp+1 (the first blank line) when cfg_vdisp < cfg_vtotal, else for the line where line_cnt == cfg_vtotal.
- R7: The four fields take effect only at a frame start (the cycle where line_cnt and pix_cnt return to 0); changes written during a frame do not affect that frame.
- R8: With cfg_htotal=41, cfg_hdisp=39, cfg_vtotal=241, cfg_vdisp=239 a frame has 242 line pulses, 240 lines carrying disp_en and one frame pulse at line 240.
- R9: When cfg_hdisp >= cfg_htotal the whole line is visible and line_pulse covers the last group of 8 pixel clocks (pix_cnt/8 == cfg_htotal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_htotal | input | 7 | Line length in groups of 8 clocks, minus one |
| cfg_hdisp | input | 7 | Visible line part in groups of 8 clocks, minus one |
| cfg_vtotal | input | 10 | Frame length in lines, minus one |
| cfg_vdisp | input | 10 | Visible lines, minus one |
| line_pulse | output | 1 | Line strobe, 8 clocks per line |
| frame_pulse | output | 1 | Frame strobe, one line per frame |
| disp_en | output | 1 | Position is inside the visible area |
| pix_cnt | output | 10 | Pixel clock position within the line |
| line_cnt | output | 10 | Line position within the frame |

## Verification
Small random field sets, rewritten at random moments, exercise the counters and the strobe placement on short frames. Each cycle is compared with a position model that applies a new setting only at a frame start, so a leak of a mid-frame write shows up as a divergence. Directed cases separate the clamped case where the visible part fills the line from the normal one, and show that a shorter frame length written mid-frame leaves the current frame at its old length. A full 320-wide, 240-line frame with two blank lines confirms the line, visible-line and frame strobe totals.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    localparam int HF_W     = 7;
    localparam int VF_W     = 10;
    localparam int GRP_LOG  = 3;
    localparam int PIX_W    = HF_W + GRP_LOG;

    typedef struct packed {
        logic [HF_W-1:0] htot;
        logic [HF_W-1:0] hvis;
        logic [VF_W-1:0] vtot;
        logic [VF_W-1:0] vvis;
    } tcfg_t;
endpackage

// File: rtl/lcdt_shadow.sv
module lcdt_shadow
    import lcdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_wrap,
    input  tcfg_t cfg_in,
    output tcfg_t cfg_q,
    output logic  primed_q
);
    typedef struct packed {
        tcfg_t cfg;
        logic  primed;
    } shd_t;

    shd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.primed = 1'b1;
        if (!st_q.primed || frame_wrap) begin
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q    = st_q.cfg;
    assign primed_q = st_q.primed;

    // R7: shadow fields only move at a frame start
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && !frame_wrap) |=> $stable(st_q.cfg));

    // R1: once running, the block stays running until reset
    p_primed_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.primed |=> st_q.primed);
endmodule

// File: rtl/lcdt_hcount.sv
module lcdt_hcount
    import lcdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [HF_W-1:0] htot,
    output logic [HF_W-1:0] grp_q,
    output logic [PIX_W-1:0] pix_q,
    output logic            line_end
);
    localparam logic [GRP_LOG-1:0] SUB_LAST = '1;

    typedef struct packed {
        logic [HF_W-1:0]    grp;
        logic [GRP_LOG-1:0] sub;
    } hpos_t;

    hpos_t st_d, st_q;

    always_comb begin
        line_end = run && (st_q.grp == htot) && (st_q.sub == SUB_LAST);
        st_d = st_q;
        if (run) begin
            if (st_q.sub == SUB_LAST) begin
                st_d.sub = '0;
                if (st_q.grp == htot) begin
                    st_d.grp = '0;
                end else begin
                    st_d.grp = st_q.grp + 1'b1;
                end
            end else begin
                st_d.sub = st_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_q = st_q.grp;
    assign pix_q = {st_q.grp, st_q.sub};

    // R2: inside a line the position advances by exactly one
    p_pix_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !line_end) |=> (pix_q == $past(pix_q) + {{(PIX_W-1){1'b0}}, 1'b1}));

    // R2: the position returns to zero after the last clock of a line
    p_pix_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (pix_q == '0));
endmodule

// File: rtl/lcdt_vcount.sv
module lcdt_vcount
    import lcdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [VF_W-1:0] vtot,
    output logic [VF_W-1:0] line_q,
    output logic            frame_wrap
);
    typedef struct packed {
        logic [VF_W-1:0] line;
    } vpos_t;

    vpos_t st_d, st_q;

    always_comb begin
        frame_wrap = step && (st_q.line == vtot);
        st_d = st_q;
        if (step) begin
            if (st_q.line == vtot) begin
                st_d.line = '0;
            end else begin
                st_d.line = st_q.line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_q = st_q.line;

    // R3: the line position only moves at the end of a line
    p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(line_q));

    // R3: the line position never passes the frame length
    p_line_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (line_q == '0));
endmodule

// File: rtl/lcd_panel_timer.sv
module lcd_panel_timer
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HF_W-1:0]  cfg_htotal,
    input  logic [HF_W-1:0]  cfg_hdisp,
    input  logic [VF_W-1:0]  cfg_vtotal,
    input  logic [VF_W-1:0]  cfg_vdisp,
    output logic             line_pulse,
    output logic             frame_pulse,
    output logic             disp_en,
    output logic [PIX_W-1:0] pix_cnt,
    output logic [VF_W-1:0]  line_cnt
);
    tcfg_t            cfg_in;
    tcfg_t            cfg;
    logic             primed;
    logic             line_end;
    logic             frame_wrap;
    logic [HF_W-1:0]  grp;
    logic [HF_W-1:0]  lp_grp;
    logic [VF_W-1:0]  fp_line;
    logic             h_vis;
    logic             v_vis;

    assign cfg_in = '{htot: cfg_htotal, hvis: cfg_hdisp,
                      vtot: cfg_vtotal, vvis: cfg_vdisp};

    lcdt_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_wrap (frame_wrap),
        .cfg_in     (cfg_in),
        .cfg_q      (cfg),
        .primed_q   (primed)
    );

    lcdt_hcount u_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (primed),
        .htot     (cfg.htot),
        .grp_q    (grp),
        .pix_q    (pix_cnt),
        .line_end (line_end)
    );

    lcdt_vcount u_vcount (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (line_end),
        .vtot       (cfg.vtot),
        .line_q     (line_cnt),
        .frame_wrap (frame_wrap)
    );

    // strobe placement, clamped when the visible part fills the period
    always_comb begin
        lp_grp  = (cfg.hvis < cfg.htot) ? cfg.hvis + 1'b1 : cfg.htot;
        fp_line = (cfg.vvis < cfg.vtot) ? cfg.vvis + 1'b1 : cfg.vtot;
        h_vis   = (grp <= cfg.hvis);
        v_vis   = (line_cnt <= cfg.vvis);
        disp_en     = primed && h_vis && v_vis;
        line_pulse  = primed && (grp == lp_grp);
        frame_pulse = primed && (line_cnt == fp_line);
    end

    // R1: nothing is driven before the first frame starts
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> (!disp_en && !line_pulse && !frame_pulse));

    // R4: the visible flag never appears on a blank line
    p_de_rows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (line_cnt <= cfg.vvis));

    // R5: with a blank part present, the line strobe stays out of the visible area
    p_lp_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && (cfg.hvis < cfg.htot)) |-> !disp_en);

    // R6: the frame strobe keeps its level through a line
    p_fp_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !line_end) |=> (frame_pulse == $past(frame_pulse)));
endmodule

// File: tb/lcd_panel_timer_bench.sv
module lcd_panel_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_htotal = '0;
    logic [6:0] cfg_hdisp = '0;
    logic [9:0] cfg_vtotal = '0;
    logic [9:0] cfg_vdisp = '0;
    logic       line_pulse, frame_pulse, disp_en;
    logic [9:0] pix_cnt, line_cnt;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    lcd_panel_timer u_lcd_panel_timer (
        .clk(clk), .rst_n(rst_n),
        .cfg_htotal(cfg_htotal), .cfg_hdisp(cfg_hdisp),
        .cfg_vtotal(cfg_vtotal), .cfg_vdisp(cfg_vdisp),
        .line_pulse(line_pulse), .frame_pulse(frame_pulse),
        .disp_en(disp_en), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
    );

    always #10 clk = ~clk;

    // position model built from the requirements
    bit m_run = 0;
    int m_h = 0, m_v = 0;
    int m_ht = 0, m_hd = 0, m_vt = 0, m_vd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_h = 0; m_v = 0;
            m_ht = 0; m_hd = 0; m_vt = 0; m_vd = 0;
        end else if (!m_run) begin
            m_run = 1; m_h = 0; m_v = 0;
            m_ht = cfg_htotal; m_hd = cfg_hdisp; m_vt = cfg_vtotal; m_vd = cfg_vdisp;
        end else begin
            m_h++;
            if (m_h == (m_ht + 1) * 8) begin
                m_h = 0;
                if (m_v == m_vt) begin
                    m_v = 0;
                    m_ht = cfg_htotal; m_hd = cfg_hdisp; m_vt = cfg_vtotal; m_vd = cfg_vdisp;
                end else begin
                    m_v++;
                end
            end
        end
    end

    function automatic bit exp_de(int h, int v, int hd, int vd);
        return (h < (hd + 1) * 8) && (v <= vd);
    endfunction

    function automatic bit exp_lp(int h, int ht, int hd);
        int g = (hd < ht) ? hd + 1 : ht;
        return (h / 8) == g;
    endfunction

    function automatic bit exp_fp(int v, int vt, int vd);
        int l = (vd < vt) ? vd + 1 : vt;
        return v == l;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!m_run) begin
                check("R1 disp_en", disp_en, 0);
                check("R1 line_pulse", line_pulse, 0);
                check("R1 frame_pulse", frame_pulse, 0);
                check("R1 pix_cnt", pix_cnt, 0);
                check("R1 line_cnt", line_cnt, 0);
            end else begin
                check("R2 pix_cnt", pix_cnt, m_h);
                check("R3 line_cnt", line_cnt, m_v);
                check("R4 disp_en", disp_en, exp_de(m_h, m_v, m_hd, m_vd));
                if (m_hd >= m_ht)
                    check("R9 line_pulse", line_pulse, exp_lp(m_h, m_ht, m_hd));
                else
                    check("R5 line_pulse", line_pulse, exp_lp(m_h, m_ht, m_hd));
                check("R6 frame_pulse", frame_pulse, exp_fp(m_v, m_vt, m_vd));
            end
        end
    end

    task automatic set_cfg(int ht, int hd, int vt, int vd);
        cfg_htotal = 7'(ht); cfg_hdisp = 7'(hd);
        cfg_vtotal = 10'(vt); cfg_vdisp = 10'(vd);
    endtask

    task automatic wait_origin();
        do @(negedge clk); while (!(pix_cnt == 0 && line_cnt == 0));
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        int seed_dummy;
        int maxl;
        int n_lp, n_vis, n_fp, fp_at;
        bit prev_lp, prev_fp, line_vis;
        seed_dummy = $urandom(32'h5eed_1234);

        // R1: reset with non-zero fields applied
        set_cfg(3, 1, 4, 2);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);   // priming cycle, still idle per R1

        // random fields, rewritten at random moments (R2..R7, R9)
        for (int i = 0; i < 120; i++) begin
            set_cfg($urandom_range(5, 0), $urandom_range(6, 0),
                    $urandom_range(6, 0), $urandom_range(7, 0));
            repeat ($urandom_range(80, 5)) @(negedge clk);
        end

        // R9: visible part fills the line
        set_cfg(2, 5, 2, 1);
        wait_origin();
        wait_origin();
        repeat (24) @(negedge clk);

        // R7: shorter frame written mid-frame must not cut the current frame
        set_cfg(3, 1, 4, 2);
        wait_origin();
        wait_origin();
        repeat (10) @(negedge clk);
        set_cfg(3, 1, 1, 0);
        maxl = 0;
        do begin
            @(negedge clk);
            if (line_cnt > maxl) maxl = line_cnt;
        end while (!(pix_cnt == 0 && line_cnt == 0));
        check("R7 old frame length kept", maxl, 4);
        maxl = 0;
        do begin
            @(negedge clk);
            if (line_cnt > maxl) maxl = line_cnt;
        end while (!(pix_cnt == 0 && line_cnt == 0));
        check("R7 new frame length applied", maxl, 1);

        // R8: 320x240 panel with two blank lines
        set_cfg(41, 39, 241, 239);
        wait_origin();
        wait_origin();
        n_lp = 0; n_vis = 0; n_fp = 0; fp_at = -1;
        prev_lp = 0; prev_fp = 0; line_vis = 0;
        do begin
            if (line_pulse && !prev_lp) n_lp++;
            if (frame_pulse && !prev_fp) begin n_fp++; fp_at = line_cnt; end
            if (disp_en) line_vis = 1;
            prev_lp = line_pulse; prev_fp = frame_pulse;
            @(negedge clk);
            if (pix_cnt == 0) begin
                if (line_vis) n_vis++;
                line_vis = 0;
            end
        end while (!(pix_cnt == 0 && line_cnt == 0));
        check("R8 line pulses per frame", n_lp, 242);
        check("R8 visible lines", n_vis, 240);
        check("R8 frame pulses", n_fp, 1);
        check("R8 frame pulse line", fp_at, 240);

        summary();
    end
endmodule